// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Auto-Incrementing Pointer

This block is the serial front end of a timekeeping core. It watches an oversampled two-wire bus (a clock line and a bidirectional open-drain data line), recognises START and STOP conditions, and answers only the 7-bit device address 1101000. The last bit of the address byte selects the direction. The block keeps a word pointer into a file of 20 byte-wide registers. Data bytes from the master are written through a simple register port. Data bytes the master reads are taken from the same port and shifted out MSB first.

The pointer is volatile and persists between transfers. In a write, the first byte after the address loads the pointer, and each later byte is stored at the pointer, which then advances. In a read, the block returns the byte at the pointer. The pointer advances only when the master acknowledges on the ninth clock. A master can therefore set the pointer with a short write, issue a repeated START and read from that location. A read with no pointer write carries on from wherever the pointer was left. Both lines pass through a two-flop synchroniser and are edge-detected on a system clock that runs at least 16 times faster than the bus clock. The STOP indication and the current pointer are exported to the clock core.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` low), the pointer reads 0, `reg_wr_o` is low and `stop_o` is low.
- R2: The block acknowledges address byte D0h (write) and D1h (read) by pulling the data line low during the ninth clock. Any other address byte is not acknowledged. After such a byte the block stays silent, writes nothing and keeps its pointer until the next START.
- R3: A START (data falls while clock is high) restarts address reception at any point, including a repeated START in the middle of a transfer. A STOP (data rises while clock is high) ends the transfer, and `stop_o` pulses for exactly one system clock.
- R4: The first byte after a write address loads the pointer and is acknowledged. A byte value of 20 or more loads 0.
- R5: Each later byte of a write is acknowledged. It produces a one-cycle `reg_wr_o` with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte, and the pointer then advances by one.
- R6: The pointer wraps from 19 to 0 when it advances, in writes and in reads.
- R7: In a read, the byte at the pointer is driven MSB first. Each bit is set up after the clock falls. A 1 bit releases the line and a 0 bit pulls it low. The line is released during the master's acknowledge clock.
- R8: In a read, the pointer advances only when the master drives its ninth bit low (acknowledge). A high ninth bit (no acknowledge) leaves the pointer unchanged, and the block releases the line and stays silent until the next START.
- R9: A read that is not preceded by a pointer write starts at the stored pointer. A pointer write followed by a repeated START and a read address returns data from the loaded pointer.
- R10: `reg_addr_o` always shows the current pointer, which is always below 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr_o | output | PTR_W | Current word pointer, also the register-port address |
| reg_wr_o | output | 1 | One-cycle write strobe for the register port |
| reg_wdata_o | output | 8 | Byte to write when `reg_wr_o` is high |
| reg_rdata_i | input | 8 | Register contents at `reg_addr_o` |
| stop_o | output | 1 | One-cycle pulse on a STOP condition |

## Verification
On every cycle, the assertions check these properties: the pointer stays in range and wraps from 19 to 0; an out-of-range pointer byte loads 0; the line is released whenever the block is idle and right after any START; every register write is acknowledged; the pointer holds still while read data bits are on the bus; and the STOP pulse lasts one cycle. Only the bench scenarios can show the rest. That covers the byte values returned in MSB-first order, the difference between acknowledged and non-acknowledged read bytes, the reuse of a pointer left behind by earlier transfers, the silence after a foreign address, and the effect of a repeated START in the middle of a write. The bench checks these against its own register image.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int BYTE_W = 8;
  localparam int BITCNT_W = 4;
  localparam logic [BITCNT_W-1:0] BYTE_BITS = BITCNT_W'(BYTE_W);

  // Transfer phase of the slave
  typedef enum logic [2:0] {
    ST_IDLE,   // ignore bus until START
    ST_ADDR,   // receiving device address byte
    ST_PTR,    // receiving word pointer byte
    ST_WDATA,  // receiving data bytes
    ST_RDATA   // transmitting data bytes
  } slv_state_e;

endpackage

// File: rtl/i2c_reset_sync.sv
module i2c_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);

  // STAGES flops of metastability filtering plus one history flop
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;            // idle bus is high
    end else begin
      pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign prev_o  = pipe_q[STAGES];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl_lvl_i,
  input  logic scl_prev_i,
  input  logic sda_lvl_i,
  input  logic sda_prev_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_held_high;

  assign scl_held_high = scl_lvl_i & scl_prev_i;
  assign scl_rise_o    = scl_lvl_i & ~scl_prev_i;
  assign scl_fall_o    = ~scl_lvl_i & scl_prev_i;
  assign start_o       = scl_held_high & sda_prev_i & ~sda_lvl_i;
  assign stop_o        = scl_held_high & ~sda_prev_i & sda_lvl_i;

endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr #(
  parameter int NUM_REGS = 20,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [PTR_W-1:0]  ptr_o
);

  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NUM_REGS);
  localparam logic [PTR_W-1:0]  LAST  = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = (load_val_i < LIMIT) ? load_val_i[PTR_W-1:0] : '0;
    end else if (inc_i) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_i || inc_i) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  // R10: pointer never leaves the register file
  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  // R6: advancing from the last register returns to zero
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && ptr_q == LAST) |=> (ptr_q == '0));

  // R4: out-of-range pointer byte lands on zero
  assert_ptr_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i >= LIMIT) |=> (ptr_q == '0));

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NUM_REGS    = 20,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              stop_o
);

  localparam int N_LINES = 2;   // index 0: clock line, 1: data line

  logic rst_sync_n;

  i2c_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // ---------------- line synchronisers ----------------
  logic [N_LINES-1:0] raw_lines, lvl, prv;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (raw_lines[g]),
      .level_o(lvl[g]),
      .prev_o (prv[g])
    );
  end

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  assign sda_lvl = lvl[1];

  i2c_bus_events u_events (
    .scl_lvl_i (lvl[0]),
    .scl_prev_i(prv[0]),
    .sda_lvl_i (lvl[1]),
    .sda_prev_i(prv[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  // ---------------- transfer sequencer ----------------
  slv_state_e            state_q, state_d, nxt_q, nxt_d;
  logic [BITCNT_W-1:0]   bitcnt_q, bitcnt_d;
  logic                  ack_q, ack_d;      // inside ninth-bit slot
  logic                  mack_q, mack_d;    // master acknowledged read byte
  logic [BYTE_W-1:0]     rx_q, rx_d, tx_q, tx_d;
  logic                  oe_q, oe_d;
  logic                  ptr_load, ptr_inc, wr_stb;
  logic [PTR_W-1:0]      ptr_q;

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    bitcnt_d = bitcnt_q;
    ack_d    = ack_q;
    mack_d   = mack_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    oe_d     = oe_q;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    wr_stb   = 1'b0;

    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (!ack_q) begin
            if (scl_rise && bitcnt_q != BYTE_BITS) begin
              rx_d     = {rx_q[BYTE_W-2:0], sda_lvl};
              bitcnt_d = bitcnt_q + 1'b1;
            end
            if (scl_fall && bitcnt_q == BYTE_BITS) begin
              bitcnt_d = '0;
              if (state_q == ST_ADDR) begin
                if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                  ack_d = 1'b1;
                  oe_d  = 1'b1;
                  nxt_d = rx_q[0] ? ST_RDATA : ST_PTR;
                end else begin
                  state_d = ST_IDLE;
                end
              end else begin
                ack_d = 1'b1;
                oe_d  = 1'b1;
                nxt_d = ST_WDATA;
                if (state_q == ST_PTR) begin
                  ptr_load = 1'b1;
                end else begin
                  wr_stb  = 1'b1;
                  ptr_inc = 1'b1;
                end
              end
            end
          end else if (scl_fall) begin
            ack_d   = 1'b0;
            oe_d    = 1'b0;
            state_d = nxt_q;
            if (nxt_q == ST_RDATA) begin
              tx_d     = reg_rdata_i;
              oe_d     = ~reg_rdata_i[BYTE_W-1];
              bitcnt_d = '0;
            end
          end
        end

        ST_RDATA: begin
          if (!ack_q) begin
            if (scl_rise && bitcnt_q != BYTE_BITS) begin
              bitcnt_d = bitcnt_q + 1'b1;
            end
            if (scl_fall && bitcnt_q == BYTE_BITS) begin
              ack_d  = 1'b1;
              oe_d   = 1'b0;
              mack_d = 1'b0;
            end else if (scl_fall && bitcnt_q != '0) begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end else begin
            if (scl_rise) begin
              mack_d  = ~sda_lvl;
              ptr_inc = ~sda_lvl;
            end
            if (scl_fall) begin
              ack_d    = 1'b0;
              bitcnt_d = '0;
              if (mack_q) begin
                tx_d = reg_rdata_i;
                oe_d = ~reg_rdata_i[BYTE_W-1];
              end else begin
                state_d = ST_IDLE;
                oe_d    = 1'b0;
              end
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      bitcnt_q <= '0;
      ack_q    <= 1'b0;
      mack_q   <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      nxt_q    <= nxt_d;
      bitcnt_q <= bitcnt_d;
      ack_q    <= ack_d;
      mack_q   <= mack_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      oe_q     <= oe_d;
    end
  end

  i2c_word_ptr #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (BYTE_W),
    .PTR_W   (PTR_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (ptr_load),
    .load_val_i(rx_q),
    .inc_i     (ptr_inc),
    .ptr_o     (ptr_q)
  );

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wr_o    = wr_stb;
  assign reg_wdata_o = rx_q;
  assign stop_o      = stop_det;

  // R2, R8: an idle slave never holds the data line
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R3: any START releases the line and restarts address reception
  assert_start_release_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_det |=> (!sda_oe_o && state_q == ST_ADDR));

  // R3: STOP indication lasts one system clock
  assert_stop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_o |=> !stop_o);

  // R5: every stored byte is acknowledged on the bus
  assert_wr_acked_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |=> sda_oe_o);

  // R8: pointer holds while read data bits are being shifted
  assert_rd_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_RDATA && !ack_q) |=> $stable(reg_addr_o));

endmodule

// File: tb/test_i2c_regfile_slave.sv
module test_i2c_regfile_slave;

  localparam int NREG = 20;
  localparam int PW   = $clog2(NREG);
  localparam int Q    = 8;            // system clocks per quarter bus bit

  logic clk, rst_n, scl, m_low;
  logic sda_oe, reg_wr, stop_p;
  logic [PW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire  sda_bus = ~(m_low | sda_oe);

  i2c_regfile_slave i_i2c_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .stop_o(stop_p)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Register file of the clock core, driven only by the port
  logic [7:0] rf [NREG];
  int wr_cnt = 0, stop_cnt = 0;
  assign reg_rdata = rf[reg_addr];
  always @(negedge clk) begin
    if (reg_wr) begin rf[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (stop_p) stop_cnt <= stop_cnt + 1;
  end

  // Expected image
  logic [7:0] exp_mem [NREG];
  int exp_ptr = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] wbuf [8];

  function automatic int load_val(int b); return (b < NREG) ? b : 0; endfunction
  function automatic int next_ptr(int p); return (p == NREG-1) ? 0 : p + 1; endfunction

  task automatic chk(string req, int got, int expv);
    compared++;
    if (got !== expv) begin
      mismatched++;
      $display("FAIL %s got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic clock_bit(input logic low, output logic smp);
    m_low = low; wait_q();
    scl = 1'b1;  wait_q();
    smp = sda_bus; wait_q();
    scl = 1'b0;  wait_q();
  endtask

  task automatic bus_start();
    m_low = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    m_low = 1'b1; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    m_low = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
    clock_bit(1'b0, ack_n);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b0, s); b[i] = s; end
    clock_bit(master_ack, s);
  endtask

  task automatic do_write(input int p, input int n);
    logic a;
    int sc = stop_cnt;
    bus_start();
    send_byte(8'hD0, a); chk("R2 write address ack", a, 0);
    send_byte(8'(p), a); chk("R4 pointer byte ack", a, 0);
    exp_ptr = load_val(p);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk("R5 data byte ack", a, 0);
      exp_mem[exp_ptr] = wbuf[i];
      exp_ptr = next_ptr(exp_ptr);
    end
    bus_stop();
    chk("R3 stop pulse count", stop_cnt - sc, 1);
    chk("R10 pointer after write", int'(reg_addr), exp_ptr);
  endtask

  task automatic do_read(input bit combined, input int p, input int n, input bit probe);
    logic a;
    logic [7:0] b;
    bus_start();
    if (combined) begin
      send_byte(8'hD0, a); chk("R9 write address ack", a, 0);
      send_byte(8'(p), a); chk("R9 pointer byte ack", a, 0);
      exp_ptr = load_val(p);
      bus_start();
    end
    send_byte(8'hD1, a); chk("R2 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n-1, b);
      chk(combined ? "R7 read data" : "R9 read at stored pointer", b, exp_mem[exp_ptr]);
      if (i < n-1) exp_ptr = next_ptr(exp_ptr);
    end
    if (probe) begin
      recv_byte(1'b0, b);
      chk("R8 silent after no-ack", b, 8'hFF);
    end
    bus_stop();
    chk("R8 pointer after read", int'(reg_addr), exp_ptr);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1-timeout got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic a;
    int sc, wc, kind, p, n;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      rf[i] = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 data line released", sda_oe, 0);
    chk("R1 pointer zero", int'(reg_addr), 0);
    chk("R1 no write strobe", reg_wr, 0);
    chk("R1 no stop pulse", stop_p, 0);

    // R9: read at stored pointer straight after reset
    do_read(1'b0, 0, 2, 1'b0);

    // R6 write wrap 18,19,0
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(18, 3);
    chk("R6 wrapped write landed", rf[0], 8'hC3);

    // R9 current-pointer read continues after wrap
    do_read(1'b0, 0, 2, 1'b0);

    // R4 out-of-range pointer byte
    do_write(5, 0);
    chk("R4 pointer loaded", int'(reg_addr), 5);
    do_write(8'h25, 0);
    chk("R4 out-of-range loads zero", int'(reg_addr), 0);

    // R2 foreign address ignored
    wc = wr_cnt;
    do_write(9, 0);
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign address not acked", a, 1);
    send_byte(8'h03, a); chk("R2 silent after foreign address", a, 1);
    send_byte(8'h55, a); chk("R2 silent after foreign address", a, 1);
    bus_stop();
    chk("R2 no write after foreign address", wr_cnt - wc, 0);
    chk("R2 pointer kept after foreign address", int'(reg_addr), 9);

    // R6 read wrap, R8 no-ack holds pointer and silences slave
    do_read(1'b1, 19, 3, 1'b0);
    chk("R6 pointer after wrapped read", int'(reg_addr), 1);
    do_read(1'b1, 7, 1, 1'b1);
    chk("R8 no-ack keeps pointer", int'(reg_addr), 7);

    // R3 repeated START in the middle of a write
    sc = stop_cnt;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'd3, a); send_byte(8'h11, a);
    exp_mem[3] = 8'h11;
    bus_start();
    send_byte(8'hD0, a); chk("R3 address acked after repeated START", a, 0);
    send_byte(8'd10, a); send_byte(8'h22, a);
    exp_mem[10] = 8'h22; exp_ptr = 11;
    bus_stop();
    chk("R3 one stop for whole transfer", stop_cnt - sc, 1);
    chk("R3 pointer after restarted write", int'(reg_addr), 11);
    do_read(1'b1, 3, 1, 1'b0);
    do_read(1'b1, 10, 2, 1'b0);

    // Random mix
    for (int t = 0; t < 24; t++) begin
      kind = $urandom % 3;
      if (kind == 0) begin
        p = $urandom % 24; n = 1 + $urandom % 5;
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(p, n);
      end else if (kind == 1) begin
        do_read(1'b1, $urandom % NREG, 1 + $urandom % 5, 1'b0);
      end else begin
        do_read(1'b0, 0, 1 + $urandom % 4, 1'b0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule